// File: doc/BRIEF.md
# Sector Lock Protection Controller

This block keeps the write-protection state of every erase sector of a parallel NOR-style flash controller. Each sector owns two bits: a soft lock, which a command can set and clear, and a hard lock, which a command can set but only reset can clear. Lock commands arrive as two bus-write strobes: a setup code followed by an action code, with the sector taken from the address of the second strobe.

The stored bits are combined with a live write-protect level and a programming-supply-valid flag to produce a combinational permission flag for the sector targeted by a pending program or erase. When the write-protect level is high, hard locks are overridden. For identification-mode reads, the block returns a two-bit lock status for a chosen sector at a fixed word offset. Command strobes are plain, one-cycle write pulses with no back-pressure: a strobe is taken on every clock edge where it is high.

Top module: `sector_lock_ctrl`

## Requirements
- R1: After reset every sector reads status 01 (soft lock set, hard lock clear), and program/erase is refused for it.
- R2: A strobe carrying 60h followed by a strobe carrying 01h sets the soft lock of the sector addressed by the second strobe, effective at the clock edge of the second strobe.
- R3: A 60h strobe followed by a 2Fh strobe sets the hard lock of the addressed sector and leaves its soft lock unchanged.
- R4: A 60h strobe followed by a D0h strobe clears the soft lock of the addressed sector when its hard lock is clear or when write-protect is high at that edge.
- R5: An unlock (60h, D0h) sent to a hard-locked sector while write-protect is low leaves both lock bits unchanged.
- R6: No command sequence clears a hard lock; only reset does.
- R7: Permission for the requested sector is high exactly when the supply is valid, its soft lock is clear, and either its hard lock is clear or write-protect is high. It follows the stored bits and inputs combinationally.
- R8: While the supply-valid input is low, permission is low for every sector.
- R9: The status read output is valid only when identification mode is active and the word offset equals 2. It then returns bit 1 = hard lock and bit 0 = soft lock (00 unlocked, 01 soft, 10 hard, 11 both). Otherwise the valid flag is low and the data is 00.
- R10: After a 60h strobe, a second strobe with any code other than 01h, 2Fh or D0h (including another 60h) ends the sequence and changes no bit. A lone action code with no preceding 60h is ignored.
- R11: A sector index of 39 or above is out of range. Commands addressed to it change no bit, and permission and status valid for it are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores lock defaults |
| cmd_stb | input | 1 | One-cycle command write strobe |
| cmd_code | input | 8 | Command code carried by the strobe |
| cmd_sect | input | 6 | Sector index carried by the strobe |
| wp_level | input | 1 | Write-protect level, high overrides hard locks |
| supply_ok | input | 1 | Programming supply valid |
| req_sect | input | 6 | Sector of the pending program or erase |
| req_allow | output | 1 | Program/erase permitted for req_sect |
| id_active | input | 1 | Identification read mode active |
| rd_sect | input | 6 | Sector of the identification read |
| rd_word | input | 15 | Word offset of the identification read |
| rd_lock_hit | output | 1 | Status read valid |
| rd_lock_bits | output | 2 | Lock status {hard, soft} |

## Verification
The embedded properties assume that reset is held low from time zero through at least one clock edge. They also assume that strobe, code, sector and write-protect are steady around each rising edge, so the sequencer state and the lock bits are only judged at edges with settled inputs. The stimulus changes every input on the falling edge and samples the combinational permission and status outputs mid-cycle. Strobes are issued as isolated single-cycle pulses, so each command is judged by the sequencer exactly once.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam logic [7:0] CODE_SETUP  = 8'h60;
  localparam logic [7:0] CODE_SOFT   = 8'h01;
  localparam logic [7:0] CODE_HARD   = 8'h2F;
  localparam logic [7:0] CODE_UNLOCK = 8'hD0;

  typedef enum logic { SEQ_IDLE, SEQ_ARMED } seq_state_t;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_SOFT,
    OP_HARD,
    OP_UNLOCK
  } lock_op_t;
endpackage

// File: rtl/lock_seq.sv
module lock_seq
  import lock_pkg::*;
#(
  parameter int NUM_SECT = 39,
  parameter int SECT_W   = $clog2(NUM_SECT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_code,
  input  logic [SECT_W-1:0] cmd_sect,
  output lock_op_t          op,
  output logic [SECT_W-1:0] op_sect
);
  localparam logic [SECT_W-1:0] LAST_SECT = SECT_W'(NUM_SECT - 1);

  seq_state_t state_q, state_d;
  logic       in_range;

  assign in_range = (cmd_sect <= LAST_SECT);
  assign op_sect  = cmd_sect;

  always_comb begin
    state_d = state_q;
    op      = OP_NONE;
    if (cmd_stb) begin
      case (state_q)
        SEQ_IDLE: begin
          if (cmd_code == CODE_SETUP) state_d = SEQ_ARMED;
        end
        SEQ_ARMED: begin
          state_d = SEQ_IDLE;
          if (in_range) begin
            case (cmd_code)
              CODE_SOFT:   op = OP_SOFT;
              CODE_HARD:   op = OP_HARD;
              CODE_UNLOCK: op = OP_UNLOCK;
              default:     op = OP_NONE;
            endcase
          end
        end
        default: state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  // R10
  armed_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_ARMED && cmd_stb) |=> (state_q == SEQ_IDLE));

  // R10
  idle_no_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SEQ_IDLE) |-> (op == OP_NONE));
endmodule

// File: rtl/lock_bank.sv
module lock_bank
  import lock_pkg::*;
#(
  parameter int NUM_SECT = 39,
  parameter int SECT_W   = $clog2(NUM_SECT)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  lock_op_t            op,
  input  logic [SECT_W-1:0]   op_sect,
  input  logic                wp_level,
  output logic [NUM_SECT-1:0] soft_q,
  output logic [NUM_SECT-1:0] hard_q
);
  for (genvar i = 0; i < NUM_SECT; i++) begin : g_sect
    logic sel;
    assign sel = (op != OP_NONE) && (op_sect == SECT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        soft_q[i] <= 1'b1;
        hard_q[i] <= 1'b0;
      end else if (sel) begin
        case (op)
          OP_SOFT:   soft_q[i] <= 1'b1;
          OP_HARD:   hard_q[i] <= 1'b1;
          OP_UNLOCK: if (!hard_q[i] || wp_level) soft_q[i] <= 1'b0;
          default:   ;
        endcase
      end
    end

    // R6
    hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(hard_q[i]));

    // R5
    held_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (op == OP_UNLOCK && op_sect == SECT_W'(i) && hard_q[i] && !wp_level)
        |=> $stable(soft_q[i]));
  end
endmodule

// File: rtl/lock_gate.sv
module lock_gate #(
  parameter int NUM_SECT  = 39,
  parameter int SECT_W    = $clog2(NUM_SECT),
  parameter int WORD_W    = 15,
  parameter int STAT_WORD = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SECT-1:0] soft_q,
  input  logic [NUM_SECT-1:0] hard_q,
  input  logic                wp_level,
  input  logic                supply_ok,
  input  logic [SECT_W-1:0]   req_sect,
  output logic                req_allow,
  input  logic                id_active,
  input  logic [SECT_W-1:0]   rd_sect,
  input  logic [WORD_W-1:0]   rd_word,
  output logic                rd_lock_hit,
  output logic [1:0]          rd_lock_bits
);
  localparam logic [SECT_W-1:0] LAST_SECT = SECT_W'(NUM_SECT - 1);

  logic req_ok, rd_ok;
  logic req_soft, req_hard;

  assign req_ok   = (req_sect <= LAST_SECT);
  assign rd_ok    = (rd_sect  <= LAST_SECT);
  assign req_soft = req_ok ? soft_q[req_sect] : 1'b1;
  assign req_hard = req_ok ? hard_q[req_sect] : 1'b1;

  assign req_allow = supply_ok && req_ok && !req_soft && (!req_hard || wp_level);

  assign rd_lock_hit  = id_active && rd_ok && (rd_word == WORD_W'(STAT_WORD));
  assign rd_lock_bits = rd_lock_hit ? {hard_q[rd_sect], soft_q[rd_sect]} : 2'b00;

  // R8
  no_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |-> !req_allow);

  // R9
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lock_hit |-> (rd_lock_bits == 2'b00));

  // R11
  range_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_sect > LAST_SECT) |-> !req_allow);
endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl
  import lock_pkg::*;
#(
  parameter int NUM_SECT  = 39,
  parameter int SECT_W    = $clog2(NUM_SECT),
  parameter int WORD_W    = 15,
  parameter int STAT_WORD = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_stb,
  input  logic [7:0]        cmd_code,
  input  logic [SECT_W-1:0] cmd_sect,
  input  logic              wp_level,
  input  logic              supply_ok,
  input  logic [SECT_W-1:0] req_sect,
  output logic              req_allow,
  input  logic              id_active,
  input  logic [SECT_W-1:0] rd_sect,
  input  logic [WORD_W-1:0] rd_word,
  output logic              rd_lock_hit,
  output logic [1:0]        rd_lock_bits
);
  lock_op_t            op;
  logic [SECT_W-1:0]   op_sect;
  logic [NUM_SECT-1:0] soft_q, hard_q;

  lock_seq #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) i_seq (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .cmd_sect(cmd_sect), .op(op), .op_sect(op_sect)
  );

  lock_bank #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W)) i_bank (
    .clk(clk), .rst_n(rst_n), .op(op), .op_sect(op_sect),
    .wp_level(wp_level), .soft_q(soft_q), .hard_q(hard_q)
  );

  lock_gate #(.NUM_SECT(NUM_SECT), .SECT_W(SECT_W), .WORD_W(WORD_W),
              .STAT_WORD(STAT_WORD)) i_gate (
    .clk(clk), .rst_n(rst_n), .soft_q(soft_q), .hard_q(hard_q),
    .wp_level(wp_level), .supply_ok(supply_ok), .req_sect(req_sect),
    .req_allow(req_allow), .id_active(id_active), .rd_sect(rd_sect),
    .rd_word(rd_word), .rd_lock_hit(rd_lock_hit), .rd_lock_bits(rd_lock_bits)
  );
endmodule

// File: tb/test_sector_lock_ctrl.sv
module test_sector_lock_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_stb = 1'b0;
  logic [7:0]  cmd_code = 8'h00;
  logic [5:0]  cmd_sect = 6'd0;
  logic        wp_level = 1'b0;
  logic        supply_ok = 1'b1;
  logic [5:0]  req_sect = 6'd0;
  logic        req_allow;
  logic        id_active = 1'b0;
  logic [5:0]  rd_sect = 6'd0;
  logic [14:0] rd_word = 15'd0;
  logic        rd_lock_hit;
  logic [1:0]  rd_lock_bits;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sector_lock_ctrl i_sector_lock_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_stb(cmd_stb), .cmd_code(cmd_code),
    .cmd_sect(cmd_sect), .wp_level(wp_level), .supply_ok(supply_ok),
    .req_sect(req_sect), .req_allow(req_allow), .id_active(id_active),
    .rd_sect(rd_sect), .rd_word(rd_word), .rd_lock_hit(rd_lock_hit),
    .rd_lock_bits(rd_lock_bits)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic strobe(input logic [7:0] code, input logic [5:0] sect);
    @(negedge clk);
    cmd_stb = 1'b1; cmd_code = code; cmd_sect = sect;
    @(negedge clk);
    cmd_stb = 1'b0; cmd_code = 8'h00;
  endtask

  task automatic seq2(input logic [7:0] code, input logic [5:0] sect);
    strobe(8'h60, sect);
    strobe(code, sect);
  endtask

  task automatic check_status(input logic [5:0] s, input logic [1:0] exp, input string tag);
    id_active = 1'b1; rd_sect = s; rd_word = 15'd2;
    #1;
    check({1'b0, rd_lock_hit, rd_lock_bits}, {2'b01, exp}, tag);
    id_active = 1'b0;
  endtask

  task automatic check_allow(input logic [5:0] s, input logic exp, input string tag);
    req_sect = s;
    #1;
    check({3'b000, req_allow}, {3'b000, exp}, tag);
  endtask

  task automatic t_reset_state();
    wp_level = 1'b1;
    check_status(6'd0,  2'b01, "R1 status s0");
    check_status(6'd17, 2'b01, "R1 status s17");
    check_status(6'd38, 2'b01, "R1 status s38");
    check_allow(6'd0, 1'b0, "R1 allow s0");
    wp_level = 1'b0;
  endtask

  task automatic t_soft_cycle();
    seq2(8'hD0, 6'd5);
    check_status(6'd5, 2'b00, "R4 unlock s5");
    check_allow(6'd5, 1'b1, "R7 allow unlocked s5");
    check_status(6'd4, 2'b01, "R4 neighbour s4 untouched");
    seq2(8'h01, 6'd5);
    check_status(6'd5, 2'b01, "R2 soft relock s5");
    check_allow(6'd5, 1'b0, "R7 deny soft s5");
  endtask

  task automatic t_hard();
    seq2(8'hD0, 6'd7);
    seq2(8'h2F, 6'd7);
    check_status(6'd7, 2'b10, "R3 hard s7");
    wp_level = 1'b0;
    check_allow(6'd7, 1'b0, "R7 hard deny wp low");
    wp_level = 1'b1;
    check_allow(6'd7, 1'b1, "R7 hard override wp high");
    seq2(8'h2F, 6'd9);
    check_status(6'd9, 2'b11, "R3 hard keeps soft s9");
    wp_level = 1'b0;
    seq2(8'hD0, 6'd9);
    check_status(6'd9, 2'b11, "R5 unlock ignored s9");
    wp_level = 1'b1;
    seq2(8'hD0, 6'd9);
    check_status(6'd9, 2'b10, "R4 unlock with wp high s9");
    check_allow(6'd9, 1'b1, "R7 allow s9 wp high");
    seq2(8'h01, 6'd9);
    seq2(8'hD0, 6'd9);
    check_status(6'd9, 2'b10, "R6 hard survives commands s9");
    wp_level = 1'b0;
  endtask

  task automatic t_supply();
    seq2(8'hD0, 6'd5);
    supply_ok = 1'b0;
    check_allow(6'd5, 1'b0, "R8 supply low s5");
    wp_level = 1'b1;
    check_allow(6'd7, 1'b0, "R8 supply low s7");
    supply_ok = 1'b1;
    check_allow(6'd5, 1'b1, "R8 supply restored s5");
    wp_level = 1'b0;
  endtask

  task automatic t_bad_seq();
    seq2(8'h55, 6'd11);
    check_status(6'd11, 2'b01, "R10 bad second code");
    strobe(8'hD0, 6'd11);
    check_status(6'd11, 2'b01, "R10 lone action code");
    strobe(8'h60, 6'd11);
    strobe(8'h60, 6'd11);
    strobe(8'hD0, 6'd11);
    check_status(6'd11, 2'b01, "R10 repeated setup discards");
  endtask

  task automatic t_range();
    seq2(8'hD0, 6'd45);
    check_status(6'd6, 2'b01, "R11 alias s6 untouched");
    check_status(6'd45 - 6'd39, 2'b01, "R11 wrap s6 untouched");
    wp_level = 1'b1;
    check_allow(6'd45, 1'b0, "R11 deny out of range");
    wp_level = 1'b0;
    id_active = 1'b1; rd_sect = 6'd45; rd_word = 15'd2;
    #1;
    check({1'b0, rd_lock_hit, rd_lock_bits}, 4'b0000, "R11 status out of range");
    id_active = 1'b0;
  endtask

  task automatic t_read_window();
    id_active = 1'b1; rd_sect = 6'd7; rd_word = 15'd3;
    #1;
    check({1'b0, rd_lock_hit, rd_lock_bits}, 4'b0000, "R9 wrong offset");
    id_active = 1'b0; rd_word = 15'd2;
    #1;
    check({1'b0, rd_lock_hit, rd_lock_bits}, 4'b0000, "R9 id mode off");
    check_status(6'd7, 2'b10, "R9 hard code 10");
    check_status(6'd5, 2'b00, "R9 unlocked code 00");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_soft_cycle();
    t_hard();
    t_supply();
    t_bad_seq();
    t_range();
    t_read_window();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check_status(6'd7, 2'b01, "R6 reset clears hard s7");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule